// File: doc/BRIEF.md
# Mixed-Width Write-Forwarding RAM Read Port

This block is a single-clock RAM with one write port and one registered read port. Each port can be a different power-of-two multiple of a base word. The array is stored as base words. A wide port therefore covers several consecutive base words, starting at an address aligned to its width.

The read output register is transparent to the write port. When a write and a read reach the same base word on the same clock edge, the written bits go straight into the read register. The comparison is done one base word at a time, and only the bits whose write enable is set are taken from the write data. Every other bit is loaded from the array as it stood before that edge. The read register also has a clock enable, a synchronous reset with a selectable priority against the enable, an asynchronous reset, and a defined power-up value.

Top module: `mixwidth_bypass_ram`

## Requirements
- R1: The write port is BASE_W<<WR_LOG2 bits wide and the read port is BASE_W<<RD_LOG2 bits wide. Addresses count base words. The low WR_LOG2 (or RD_LOG2) address bits are ignored, so each access is aligned to its width. Sub-word k of a port sits in bits [k*BASE_W +: BASE_W] and maps to base word (aligned address + k).
- R2: At power-up, array base word i holds (41*i + 23) modulo 2^BASE_W.
- R3: Before any clock edge or reset, the read output equals the parameter RD_INIT.
- R4: When rd_en is 1 and no synchronous reset applies, the read register loads, on the clock edge, the array contents at the read address as they were before that edge's write.
- R5: On that same edge, for each read base word that equals a written base word, every bit whose wr_be bit is 1 takes the matching wr_data bit. Bits with wr_be at 0 keep the array value.
- R6: A write changes only the array bits whose wr_be bit is 1. Later reads return the new contents.
- R7: When rd_en is 0 (and no overriding synchronous reset applies), the read output holds its value, and a matching write is not forwarded. The write still updates the array.
- R8: While rd_arst is 1, the read output equals ARST_VAL. It takes that value at once, without waiting for a clock edge.
- R9: With SRST_NEEDS_EN=1, rd_srst loads SRST_VAL only on edges where rd_en is 1. With SRST_NEEDS_EN=0, rd_srst loads SRST_VAL whatever rd_en is.
- R10: A synchronous reset of the read register does not block a write made on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports, rising edge |
| wr_addr | input | ADDR_W | Write base-word address |
| wr_data | input | BASE_W<<WR_LOG2 | Write data |
| wr_be | input | BASE_W<<WR_LOG2 | Per-bit write enables |
| rd_addr | input | ADDR_W | Read base-word address |
| rd_en | input | 1 | Read register clock enable |
| rd_srst | input | 1 | Read register synchronous reset, active high |
| rd_arst | input | 1 | Read register asynchronous reset, active high |
| rd_q | output | BASE_W<<RD_LOG2 | Registered read data |

## Verification
The bench runs two instances together: one with a wide write port and a narrow read port, and one the other way round, each with a different reset priority. The key cases are partial bit-enable writes to the word being read. A design that forwarded whole words would corrupt the unwritten bits, and one that skipped forwarding would return stale data. Collisions on only one sub-word of the wider port catch a bad sub-address expansion, which shows up as data landing in the wrong slice. Reset is checked with the enable both high and low, and while a write is in flight, to catch a wrong priority or a reset that also blocks the array write. A disabled read during a matching write catches forwarding that ignores the enable.

// File: rtl/mwr_pkg.sv
package mwr_pkg;

  // Power-up content of base word idx; callers truncate to their width.
  function automatic logic [63:0] seed_word(input int idx);
    return 64'(idx * 41 + 23);
  endfunction

endpackage

// File: rtl/mwr_array.sv
module mwr_array #(
  parameter int BASE_W  = 8,
  parameter int ADDR_W  = 4,
  parameter int WR_LOG2 = 1,
  parameter int RD_LOG2 = 0
) (
  input  logic                          clk,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [(BASE_W<<WR_LOG2)-1:0]  wr_data,
  input  logic [(BASE_W<<WR_LOG2)-1:0]  wr_be,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [(BASE_W<<RD_LOG2)-1:0]  rd_word
);
  import mwr_pkg::*;

  localparam int DEPTH = 1 << ADDR_W;
  localparam int WR_N  = 1 << WR_LOG2;
  localparam int RD_N  = 1 << RD_LOG2;
  localparam logic [ADDR_W-1:0] WR_LOW = ADDR_W'(WR_N - 1);
  localparam logic [ADDR_W-1:0] RD_LOW = ADDR_W'(RD_N - 1);

  logic [BASE_W-1:0] mem [DEPTH];
  logic [ADDR_W-1:0] wr_base;
  logic [ADDR_W-1:0] rd_base;

  assign wr_base = wr_addr & ~WR_LOW;
  assign rd_base = rd_addr & ~RD_LOW;

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = BASE_W'(seed_word(i));
    end
  end

  // Per-bit masked write, one base word per write sub-word.
  always_ff @(posedge clk) begin
    for (int w = 0; w < WR_N; w++) begin
      for (int b = 0; b < BASE_W; b++) begin
        if (wr_be[w*BASE_W + b]) begin
          mem[wr_base | ADDR_W'(w)][b] <= wr_data[w*BASE_W + b];
        end
      end
    end
  end

  for (genvar r = 0; r < RD_N; r++) begin : g_rd
    assign rd_word[r*BASE_W +: BASE_W] = mem[rd_base | ADDR_W'(r)];
  end

endmodule

// File: rtl/mwr_bypass.sv
module mwr_bypass #(
  parameter int BASE_W  = 8,
  parameter int ADDR_W  = 4,
  parameter int WR_LOG2 = 1,
  parameter int RD_LOG2 = 0
) (
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [(BASE_W<<WR_LOG2)-1:0]  wr_data,
  input  logic [(BASE_W<<WR_LOG2)-1:0]  wr_be,
  input  logic [ADDR_W-1:0]             rd_addr,
  output logic [(BASE_W<<RD_LOG2)-1:0]  fwd_mask,
  output logic [(BASE_W<<RD_LOG2)-1:0]  fwd_data
);
  localparam int WR_N = 1 << WR_LOG2;
  localparam int RD_N = 1 << RD_LOG2;
  localparam logic [ADDR_W-1:0] WR_LOW = ADDR_W'(WR_N - 1);
  localparam logic [ADDR_W-1:0] RD_LOW = ADDR_W'(RD_N - 1);

  logic [ADDR_W-1:0] wr_base;
  logic [ADDR_W-1:0] rd_base;

  assign wr_base = wr_addr & ~WR_LOW;
  assign rd_base = rd_addr & ~RD_LOW;

  // Compare every read base word against every written base word.
  always_comb begin
    fwd_mask = '0;
    fwd_data = '0;
    for (int r = 0; r < RD_N; r++) begin
      for (int w = 0; w < WR_N; w++) begin
        if ((rd_base | ADDR_W'(r)) == (wr_base | ADDR_W'(w))) begin
          fwd_mask[r*BASE_W +: BASE_W] = wr_be[w*BASE_W +: BASE_W];
          fwd_data[r*BASE_W +: BASE_W] = wr_data[w*BASE_W +: BASE_W]
                                       & wr_be[w*BASE_W +: BASE_W];
        end
      end
    end
  end

endmodule

// File: rtl/mwr_rdreg.sv
module mwr_rdreg #(
  parameter int          W             = 8,
  parameter logic [W-1:0] RD_INIT      = '0,
  parameter logic [W-1:0] ARST_VAL     = '0,
  parameter logic [W-1:0] SRST_VAL     = '0,
  parameter bit          SRST_NEEDS_EN = 1'b1
) (
  input  logic         clk,
  input  logic         arst,
  input  logic         srst,
  input  logic         en,
  input  logic [W-1:0] arr_data,
  input  logic [W-1:0] fmask,
  input  logic [W-1:0] fdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_r = RD_INIT;
  logic [W-1:0] merged;

  assign merged = (arr_data & ~fmask) | (fdata & fmask);
  assign q      = q_r;

  if (SRST_NEEDS_EN) begin : g_srst_gated
    always_ff @(posedge clk or posedge arst) begin
      if (arst)     q_r <= ARST_VAL;
      else if (en)  q_r <= srst ? SRST_VAL : merged;
    end
  end else begin : g_srst_over
    always_ff @(posedge clk or posedge arst) begin
      if (arst)      q_r <= ARST_VAL;
      else if (srst) q_r <= SRST_VAL;
      else if (en)   q_r <= merged;
    end
  end

endmodule

// File: rtl/mixwidth_bypass_ram.sv
module mixwidth_bypass_ram #(
  parameter int BASE_W  = 8,
  parameter int ADDR_W  = 4,
  parameter int WR_LOG2 = 1,
  parameter int RD_LOG2 = 0,
  parameter logic [(BASE_W<<RD_LOG2)-1:0] RD_INIT  = '0,
  parameter logic [(BASE_W<<RD_LOG2)-1:0] ARST_VAL = '0,
  parameter logic [(BASE_W<<RD_LOG2)-1:0] SRST_VAL = '0,
  parameter bit SRST_NEEDS_EN = 1'b1
) (
  input  logic                          clk,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [(BASE_W<<WR_LOG2)-1:0]  wr_data,
  input  logic [(BASE_W<<WR_LOG2)-1:0]  wr_be,
  input  logic [ADDR_W-1:0]             rd_addr,
  input  logic                          rd_en,
  input  logic                          rd_srst,
  input  logic                          rd_arst,
  output logic [(BASE_W<<RD_LOG2)-1:0]  rd_q
);
  localparam int RD_W = BASE_W << RD_LOG2;

  logic [RD_W-1:0] arr_data;
  logic [RD_W-1:0] fwd_mask;
  logic [RD_W-1:0] fwd_data;

  mwr_array #(
    .BASE_W(BASE_W), .ADDR_W(ADDR_W), .WR_LOG2(WR_LOG2), .RD_LOG2(RD_LOG2)
  ) u_array (
    .clk(clk), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .rd_addr(rd_addr), .rd_word(arr_data)
  );

  mwr_bypass #(
    .BASE_W(BASE_W), .ADDR_W(ADDR_W), .WR_LOG2(WR_LOG2), .RD_LOG2(RD_LOG2)
  ) u_bypass (
    .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .rd_addr(rd_addr), .fwd_mask(fwd_mask), .fwd_data(fwd_data)
  );

  mwr_rdreg #(
    .W(RD_W), .RD_INIT(RD_INIT), .ARST_VAL(ARST_VAL),
    .SRST_VAL(SRST_VAL), .SRST_NEEDS_EN(SRST_NEEDS_EN)
  ) u_rdreg (
    .clk(clk), .arst(rd_arst), .srst(rd_srst), .en(rd_en),
    .arr_data(arr_data), .fmask(fwd_mask), .fdata(fwd_data), .q(rd_q)
  );

endmodule

// File: rtl/mwr_checker.sv
module mwr_checker #(
  parameter int           W             = 8,
  parameter logic [W-1:0] ARST_VAL      = '0,
  parameter logic [W-1:0] SRST_VAL      = '0,
  parameter bit           SRST_NEEDS_EN = 1'b1
) (
  input logic         clk,
  input logic         rd_arst,
  input logic         rd_srst,
  input logic         rd_en,
  input logic [W-1:0] rd_q,
  input logic [W-1:0] arr_data,
  input logic [W-1:0] fwd_mask,
  input logic [W-1:0] fwd_data
);

  AST_ARST_HOLDS: assert property (@(posedge clk)
    rd_arst |-> rd_q == ARST_VAL);  // R8

  AST_DISABLED_HOLD: assert property (@(posedge clk) disable iff (rd_arst)
    (!rd_en && (SRST_NEEDS_EN || !rd_srst)) |=> ($stable(rd_q) || rd_arst));  // R7

  AST_FWD_BITS: assert property (@(posedge clk) disable iff (rd_arst)
    (rd_en && !rd_srst) |=>
      ((((rd_q ^ $past(fwd_data)) & $past(fwd_mask)) == '0) || rd_arst));  // R5

  AST_ARRAY_BITS: assert property (@(posedge clk) disable iff (rd_arst)
    (rd_en && !rd_srst) |=>
      ((((rd_q ^ $past(arr_data)) & ~$past(fwd_mask)) == '0) || rd_arst));  // R4

  AST_SRST_LOADS: assert property (@(posedge clk) disable iff (rd_arst)
    (rd_en && rd_srst) |=> (rd_q == SRST_VAL || rd_arst));  // R9

  if (!SRST_NEEDS_EN) begin : g_over
    AST_SRST_OVERRIDES: assert property (@(posedge clk) disable iff (rd_arst)
      rd_srst |=> (rd_q == SRST_VAL || rd_arst));  // R9
  end

endmodule

bind mixwidth_bypass_ram mwr_checker #(
  .W(RD_W), .ARST_VAL(ARST_VAL), .SRST_VAL(SRST_VAL), .SRST_NEEDS_EN(SRST_NEEDS_EN)
) u_chk (
  .clk(clk), .rd_arst(rd_arst), .rd_srst(rd_srst), .rd_en(rd_en), .rd_q(rd_q),
  .arr_data(arr_data), .fwd_mask(fwd_mask), .fwd_data(fwd_data)
);

// File: tb/mixwidth_bypass_ram_test.sv
`timescale 1ns/1ps
module mixwidth_bypass_ram_test;

  localparam logic [7:0]  INIT_A = 8'h3C, ARST_A = 8'hE1, SRST_A = 8'h96;
  localparam logic [15:0] INIT_B = 16'hBEEF, ARST_B = 16'h1357, SRST_B = 16'h2468;

  // {wr_be, wr_addr, wr_data, rd_addr}; read enabled, no reset
  localparam logic [39:0] VEC [10] = '{
    {16'h0000, 4'h3, 16'h0000, 4'h3},
    {16'hFFFF, 4'h4, 16'hABCD, 4'h4},
    {16'h0F0F, 4'h6, 16'h1234, 4'h7},
    {16'h0000, 4'h0, 16'h0000, 4'h5},
    {16'hFF00, 4'h9, 16'h5A5A, 4'h8},
    {16'hF0F0, 4'h8, 16'hC3C3, 4'h9},
    {16'h0000, 4'h0, 16'h0000, 4'h6},
    {16'h00FF, 4'h2, 16'h7788, 4'h2},
    {16'hFFFF, 4'hE, 16'hDEAD, 4'hF},
    {16'h0000, 4'h0, 16'h0000, 4'hE}
  };

  logic        clk = 1'b0;
  logic [3:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, wr_be = '0;
  logic        rd_en = 1'b0, rd_srst = 1'b0, rd_arst = 1'b0;
  logic [7:0]  q_a;
  logic [15:0] q_b;

  logic [127:0] m_a, m_b;
  logic [7:0]   e_a;
  logic [15:0]  e_b;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  mixwidth_bypass_ram #(
    .BASE_W(8), .ADDR_W(4), .WR_LOG2(1), .RD_LOG2(0),
    .RD_INIT(INIT_A), .ARST_VAL(ARST_A), .SRST_VAL(SRST_A), .SRST_NEEDS_EN(1'b1)
  ) uut (
    .clk(clk), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
    .rd_addr(rd_addr), .rd_en(rd_en), .rd_srst(rd_srst), .rd_arst(rd_arst), .rd_q(q_a)
  );

  mixwidth_bypass_ram #(
    .BASE_W(8), .ADDR_W(4), .WR_LOG2(0), .RD_LOG2(1),
    .RD_INIT(INIT_B), .ARST_VAL(ARST_B), .SRST_VAL(SRST_B), .SRST_NEEDS_EN(1'b0)
  ) uut_b (
    .clk(clk), .wr_addr(wr_addr), .wr_data(wr_data[7:0]), .wr_be(wr_be[7:0]),
    .rd_addr(rd_addr), .rd_en(rd_en), .rd_srst(rd_srst), .rd_arst(rd_arst), .rd_q(q_b)
  );

  function automatic logic [15:0] peek(input logic [127:0] m, input int wl, input int rl,
      input logic [3:0] wa, input logic [3:0] ra, input logic [15:0] be, input logic [15:0] wd);
    logic [15:0] res = '0;
    for (int s = 0; s < (1 << rl); s++) begin
      int a;
      a = (int'(ra) & ~((1 << rl) - 1)) + s;
      for (int b = 0; b < 8; b++) begin
        res[s*8+b] = m[a*8+b];
        for (int w = 0; w < (1 << wl); w++) begin
          if (((int'(wa) & ~((1 << wl) - 1)) + w) == a && be[w*8+b]) res[s*8+b] = wd[w*8+b];
        end
      end
    end
    return res;
  endfunction

  function automatic logic [127:0] poke(input logic [127:0] m, input int wl,
      input logic [3:0] wa, input logic [15:0] be, input logic [15:0] wd);
    for (int w = 0; w < (1 << wl); w++) begin
      int a;
      a = (int'(wa) & ~((1 << wl) - 1)) + w;
      for (int b = 0; b < 8; b++) if (be[w*8+b]) m[a*8+b] = wd[w*8+b];
    end
    return m;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_both(input string req);
    check({req, " narrow-read"}, {8'h00, q_a}, {8'h00, e_a});
    check({req, " wide-read"}, q_b, e_b);
  endtask

  task automatic step(input logic [15:0] be, input logic [3:0] wa, input logic [15:0] wd,
                      input logic [3:0] ra, input logic en, input logic sr, input string req);
    logic [15:0] pa, pb;
    @(negedge clk);
    wr_be = be; wr_addr = wa; wr_data = wd; rd_addr = ra; rd_en = en; rd_srst = sr;
    @(posedge clk);
    pa = peek(m_a, 1, 0, wa, ra, be, wd);
    pb = peek(m_b, 0, 1, wa, ra, be, wd);
    if (en) e_a = sr ? SRST_A : pa[7:0];
    if (sr) e_b = SRST_B; else if (en) e_b = pb;
    m_a = poke(m_a, 1, wa, be, wd);
    m_b = poke(m_b, 0, wa, be, wd);
    #1;
    check_both(req);
  endtask

  task automatic async_reset();
    @(negedge clk);
    wr_be = '0; rd_en = 1'b1; rd_srst = 1'b0;
    #0.5 rd_arst = 1'b1;
    #0.5;
    e_a = ARST_A; e_b = ARST_B;
    check_both("R8 immediate");
    @(posedge clk); #1;
    check_both("R8 held over edge");
    @(negedge clk);
    rd_arst = 1'b0; rd_en = 1'b0;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      m_a[i*8 +: 8] = 8'(i * 41 + 23);
      m_b[i*8 +: 8] = 8'(i * 41 + 23);
    end
    e_a = INIT_A; e_b = INIT_B;
    #1;
    check_both("R3 power-up");

    // R1 R2 R4 R5 R6: table-driven reads, writes and collisions
    for (int v = 0; v < 10; v++) begin
      step(VEC[v][39:24], VEC[v][23:20], VEC[v][19:4], VEC[v][3:0], 1'b1, 1'b0,
           "R1 R2 R4 R5 R6 vector");
    end

    async_reset();

    // R7: disabled read during a matching write holds, write still lands
    step(16'hFFFF, 4'h3, 16'h9999, 4'h3, 1'b0, 1'b0, "R7 hold");
    step(16'h0000, 4'h0, 16'h0000, 4'h3, 1'b1, 1'b0, "R6 R7 readback");

    // R9 with enable high; R10 write under reset
    step(16'h0FF0, 4'hA, 16'h1111, 4'hA, 1'b1, 1'b1, "R9 srst enabled");
    step(16'h0000, 4'h0, 16'h0000, 4'hA, 1'b1, 1'b0, "R10 readback");
    // R9 with enable low: gated mode holds, override mode resets
    step(16'h0000, 4'h0, 16'h0000, 4'hB, 1'b0, 1'b1, "R9 srst disabled");
    step(16'h00F0, 4'hB, 16'h0050, 4'hB, 1'b1, 1'b0, "R5 partial");

    async_reset();
    step(16'h0000, 4'h0, 16'h0000, 4'h4, 1'b1, 1'b0, "R4 after arst");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule